// File: doc/BRIEF.md
# SPI Master Serial Clock and Shift Engine

This block is the master side of a serial peripheral link. It derives the serial clock from the peripheral clock through a 7-bit rate code. It then moves one parallel word out on MOSI while it gathers one word from MISO, most significant bit first. A one-clock `start` strobe begins a transfer. A one-clock `done` pulse marks its end, and `rx_word` holds the received word from that pulse onward.

Two configuration bits give four clocking schemes. `rise_active` picks the active edge of SCLK: it is the falling edge when the bit is 0 and the rising edge when it is 1. `tx_lead` moves each data bit half a serial-clock cycle ahead of the active edge. Without the lead, a bit is driven on the active edge and MISO is sampled on the following edge. With the lead, a bit is driven half a cycle early and MISO is sampled on the active edge itself. The rate code and both mode bits are captured when a transfer is accepted.

Top module: `spi_master_engine`

## Requirements
- R1: For a rate code `baud_sel` from 3 to 127, one SCLK period lasts `baud_sel`+1 peripheral clocks.
- R2: For rate codes 0, 1 and 2, one SCLK period lasts 4 peripheral clocks. No SCLK level lasts less than 2 peripheral clocks.
- R3: For a divisor D, SCLK stays high for D−floor(D/2) peripheral clocks and low for floor(D/2) clocks within a transfer.
- R4: When no transfer is in progress, SCLK rests at its idle level. The idle level is 1 when `rise_active`=0 and 0 when `rise_active`=1.
- R5: With `tx_lead`=0, SCLK leaves the idle level in the clock after the start is accepted. MOSI changes only on the edges that leave the idle level. MISO is sampled on the edges that return to the idle level.
- R6: With `tx_lead`=1, SCLK stays at the idle level for one half period after the start is accepted, while the first bit is already on MOSI. MISO is sampled on the edges that leave the idle level.
- R7: `tx_word` bit WORD_W−1 is sent first and the rest follow in descending order. The first bit sampled from MISO lands in `rx_word` bit WORD_W−1. Each transfer makes exactly 2·WORD_W SCLK edges.
- R8: `done` is high for exactly one clock. It appears WORD_W·D clocks after the clock edge that accepts `start`, with `rx_word` valid in that same cycle.
- R9: A `start` that arrives during a transfer is ignored. The word in flight is unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_sel | input | 7 | Rate code that sets the SCLK divisor |
| rise_active | input | 1 | 0: falling edge active, idle high; 1: rising edge active, idle low |
| tx_lead | input | 1 | 1: each bit leads its active edge by half a period |
| start | input | 1 | One-clock request to begin a transfer |
| tx_word | input | 8 | Word to send, captured with an accepted start |
| rx_word | output | 8 | Received word, updated with done |
| done | output | 1 | One-clock pulse at the end of a transfer |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Some properties are checked on every cycle. `done` never lasts two cycles and always follows the end of the final half-period. A busy start never ends or restarts a transfer. SCLK returns to idle when `done` fires, and no SCLK level is shorter than two clocks. MOSI moves only at a bit-advance event. Other behaviour only the bench's sweeps can show. These sweeps cover every scheme and a wide range of rate codes against a slave model. They show the exact period per rate code, the high/low split for odd divisors, and which edge the design samples on. They also show the word contents in both directions and the cycle on which `done` arrives.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // Rate codes below this value all map to the fastest divisor
  localparam int unsigned FAST_CODE_LIMIT = 3;
  localparam int unsigned FASTEST_DIV     = 4;

  // Peripheral clocks per serial clock period for a given rate code
  function automatic int unsigned eff_divisor(input int unsigned code);
    if (code < FAST_CODE_LIMIT) return FASTEST_DIV;
    return code + 1;
  endfunction

  // Clocks spent at the high level (takes the extra clock of an odd divisor)
  function automatic int unsigned high_span(input int unsigned div);
    return (div + 1) / 2;
  endfunction

  // Clocks spent at the low level
  function automatic int unsigned low_span(input int unsigned div);
    return div / 2;
  endfunction
endpackage

// File: rtl/spi_eng_timer.sv
module spi_eng_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] span,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  // Fires on the last clock of the current half-period
  assign expire = run && (cnt_q == span - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clear || expire) cnt_q <= '0;
    else if (run)             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_eng_phase.sv
module spi_eng_phase #(
  parameter int STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic odd,
  output logic last
);
  localparam int PH_W = $clog2(STEPS);

  logic [PH_W-1:0] idx_q;

  assign odd  = idx_q[0];
  assign last = (idx_q == PH_W'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clear) idx_q <= '0;
    else if (step)  idx_q <= idx_q + PH_W'(1);
  end
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              capture,
  input  logic              advance,
  input  logic              finish,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] sr_q;
  logic              cap_q;
  logic [WORD_W-1:0] sr_next;

  // Sent bits leave at the top, sampled bits enter at the bottom
  assign sr_next = (sr_q << 1) | WORD_W'(cap_q);
  assign mosi    = sr_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      cap_q   <= 1'b0;
      rx_word <= '0;
    end else begin
      if (load)         sr_q <= load_word;
      else if (advance) sr_q <= sr_next;
      if (capture)      cap_q <= miso;
      if (finish)       rx_word <= sr_next;
    end
  end
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int BRR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BRR_W-1:0]  baud_sel,
  input  logic              rise_active,
  input  logic              tx_lead,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int DIV_W = BRR_W + 1;
  localparam int STEPS = 2 * WORD_W;

  logic             busy_q;
  logic [DIV_W-1:0] div_q;
  logic             rise_q;
  logic             lead_q;
  logic             done_q;

  // Named events shared with the checker
  logic             accept;
  logic             phase_end;
  logic             odd_phase;
  logic             last_phase;
  logic             sample_evt;
  logic             shift_evt;
  logic             finish_evt;
  logic             away_level;
  logic             level_now;
  logic [DIV_W-1:0] span;

  assign accept = start && !busy_q;

  // Even half-periods carry the drive event, odd ones end after the sample;
  // the lead only selects which of them sits away from the idle level.
  assign away_level = lead_q ? odd_phase : !odd_phase;
  assign level_now  = busy_q ? (!rise_q ^ away_level) : !rise_active;
  assign span       = level_now ? DIV_W'(high_span(32'(div_q)))
                                : DIV_W'(low_span(32'(div_q)));

  assign sample_evt = phase_end && !odd_phase;
  assign shift_evt  = phase_end &&  odd_phase && !last_phase;
  assign finish_evt = phase_end &&  odd_phase &&  last_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= DIV_W'(FASTEST_DIV);
      rise_q <= 1'b0;
      lead_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish_evt;
      if (accept) begin
        busy_q <= 1'b1;
        div_q  <= DIV_W'(eff_divisor(32'(baud_sel)));
        rise_q <= rise_active;
        lead_q <= tx_lead;
      end else if (finish_evt) begin
        busy_q <= 1'b0;
      end
    end
  end

  spi_eng_timer #(.CNT_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .run    (busy_q),
    .span   (span),
    .expire (phase_end)
  );

  spi_eng_phase #(.STEPS(STEPS)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (phase_end),
    .odd   (odd_phase),
    .last  (last_phase)
  );

  spi_eng_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (tx_word),
    .capture   (sample_evt),
    .advance   (shift_evt),
    .finish    (finish_evt),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  assign sclk = level_now;
  assign done = done_q;
endmodule

// File: rtl/spi_master_engine_chk.sv
module spi_master_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic rise_active,
  input logic shift_evt,
  input logic finish_evt
);
  // R8: done is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done only follows the close of the final half-period
  assert_done_after_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(finish_evt));

  // R9: a start during a transfer neither ends nor completes it early
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finish_evt) |=> (busy && !done));

  // R4: the serial clock is back at idle when the completion pulse appears
  assert_idle_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sclk == !rise_active));

  // R2: no serial clock level inside a transfer is shorter than two clocks
  assert_min_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (sclk != $past(sclk))) |=> $stable(sclk));

  // R5: data out moves only on a bit-advance event while busy
  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(shift_evt)) |-> $stable(mosi));
endmodule

bind spi_master_engine spi_master_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy_q),
  .done        (done),
  .sclk        (sclk),
  .mosi        (mosi),
  .rise_active (rise_active),
  .shift_evt   (shift_evt),
  .finish_evt  (finish_evt)
);

// File: tb/test_spi_master_engine.sv
`timescale 1ns/1ps
module test_spi_master_engine;
  localparam int W  = 8;
  localparam int BW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] baud_sel = '0;
  logic          rise_active = 1'b0;
  logic          tx_lead = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  tx_word = '0;
  logic [W-1:0]  rx_word;
  logic          done;
  logic          sclk;
  logic          mosi;
  logic          miso = 1'b0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  spi_master_engine #(.WORD_W(W), .BRR_W(BW)) i_spi_master_engine (
    .clk(clk), .rst_n(rst_n), .baud_sel(baud_sel), .rise_active(rise_active),
    .tx_lead(tx_lead), .start(start), .tx_word(tx_word), .rx_word(rx_word),
    .done(done), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Period from the rate rule, written independently of the design
  function automatic int bench_div(input int code);
    if (code <= 2) return 4;
    return code + 1;
  endfunction

  task automatic run_xfer(input int code, input bit rise, input bit lead,
                          input logic [W-1:0] txw, input logic [W-1:0] slv, input bit inj);
    int d, hi, lo, c, edges, nsamp, last_s, last_rise, last_fall, bad;
    logic idle, prev, toward;
    logic [W-1:0] got;
    string ptag;
    d  = bench_div(code);
    lo = d / 2;
    hi = d - lo;
    idle = rise ? 1'b0 : 1'b1;
    ptag = (code <= 2) ? "R2 period" : "R1 period";
    @(negedge clk);
    baud_sel = BW'(code); rise_active = rise; tx_lead = lead;
    tx_word = txw; miso = slv[W-1];
    @(negedge clk);
    check("R4 idle before start", sclk, idle);
    start = 1'b1;
    @(posedge clk);
    c = 0; edges = 0; nsamp = 0; last_s = -1; last_rise = -1; last_fall = -1;
    prev = idle; got = '0;
    forever begin
      @(negedge clk);
      if (c == 0) start = 1'b0;
      if (inj && c == 2) begin start = 1'b1; tx_word = ~txw; end
      if (inj && c == 3) start = 1'b0;
      if (c == 0) begin
        if (lead) check("R6 level after accept", sclk, idle);
        else      check("R5 level after accept", sclk, !idle);
      end
      if (sclk !== prev) begin
        edges++;
        toward = (sclk == idle);
        if (lead ? !toward : toward) begin
          if (nsamp < W) got[W-1-nsamp] = mosi;
          if (nsamp == 0 && lead) check("R6 first sample edge", c, idle ? hi : lo);
          if (nsamp > 0) check(ptag, c - last_s, d);
          last_s = c;
          nsamp++;
          if (nsamp < W) miso = slv[W-1-nsamp];
        end
        if (sclk) begin
          if (last_fall >= 0) check("R3 low span", c - last_fall, lo);
          last_rise = c;
        end else begin
          if (last_rise >= 0) check("R3 high span", c - last_rise, hi);
          last_fall = c;
        end
        prev = sclk;
      end
      if (done) begin
        check("R8 done cycle", c, W * d);
        check("R7 received word", rx_word, slv);
        check("R7 sent word", got, txw);
        check("R7 edge count", edges, 2 * W);
        check("R4 idle after done", sclk, idle);
        @(negedge clk);
        check("R8 done width", done, 1'b0);
        if (inj) begin
          bad = 0;
          for (int k = 0; k < 3 * d; k++) begin
            if (sclk !== idle || done !== 1'b0) bad++;
            @(negedge clk);
          end
          check("R9 no second transfer", bad, 0);
        end
        break;
      end
      if (c > W * d + 8) begin
        check("R8 done timeout", c, W * d);
        break;
      end
      @(posedge clk);
      c++;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R4 reset sclk idle", sclk, 1'b1);
    check("R8 reset done low", done, 1'b0);
    check("R7 reset rx_word", rx_word, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int code = 0; code <= 40; code++) begin
        run_xfer(code, m[1], m[0], W'(code * 37 + m * 11) ^ 8'hA5,
                 W'(code * 13 + m * 91 + 7), (code % 5) == 0);
      end
    end
    for (int code = 100; code <= 127; code++)
      run_xfer(code, 1'b1, 1'b1, W'(code * 29), W'(~(code * 3)), (code % 9) == 0);
    for (int m = 0; m < 3; m++)
      run_xfer(127, m[1], m[0], 8'h81, 8'h7E, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule